// File: doc/BRIEF.md
# Triggered Sample Pipeline with Framed Serial Readout

This block stores one digitized sample for every front-end channel on every clock. Each clock's samples form one column of a circular buffer. A level-1 trigger selects the column written a programmable number of clocks earlier. The block then sends that column out as a frame: a fixed header, the column address, an error flag, and then one channel value per clock.

Triggers that arrive while a frame is being sent wait in a small ordered queue. A column held by a waiting trigger is protected from being overwritten. When nothing is being sent, the serial line carries a single-clock sync pulse at a fixed period, so the receiver can stay aligned between frames.

Top module: `trig_sample_pipe`

## Requirements
- R1: Every clock out of reset, the input samples are written to the column at the write pointer. The pointer counts 0 to 191 and then wraps to 0, and it is 0 in the first clock after reset. A trigger seen at a clock edge selects column (pointer − latency) mod 192, where the pointer is the column being written at that same edge. With a latency of 0, the column being written in that cycle is selected.
- R2: A latency input of 192 or more is treated as 191, which selects the oldest column still held.
- R3: The frame is 140 clocks on the line output. Clocks 0–2 are high. Clocks 3–10 carry the 8-bit column address, most significant bit first. Clock 11 carries the error flag. Clocks 12–139 carry channels 0 to 127 in that order on the sample output, with the sample-valid output high and the line output low.
- R4: When the block is idle and the queue is empty, a trigger sampled at clock edge E starts a frame whose clock 0 is the cycle after edge E+1. The line is low in the cycle between edge E and edge E+1.
- R5: Up to 4 waiting triggers are held and served in arrival order. A waiting frame starts in the clock right after the previous frame's last sample. A trigger that arrives when all 4 slots are taken and none is being released is dropped and produces no frame.
- R6: A column held by a waiting trigger is not written until its frame has loaded it. The frame therefore carries the data captured when that column was selected.
- R7: The error flag is set by a dropped trigger or by a write blocked under R6. Once set, it stays set until reset. Each frame's error bit is the flag's value when that frame starts.
- R8: While idle with no waiting trigger, the line output pulses high for one clock every 70 clocks and is low otherwise. The first pulse after reset falls in the 70th cycle after reset.
- R9: After a frame whose queue is then empty, the line stays low for 69 clocks and pulses in the 70th clock after the last sample.
- R10: A synchronous active-high reset clears the write pointer, the waiting triggers, any frame in progress, the sync counter and the error flag. The line and sample-valid outputs are low in the cycle after a reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| samp_i | input | N_CH*SW (1024) | One sample per channel; channel k in bits [k*SW +: SW] |
| trig_i | input | 1 | Level-1 trigger, one clock per trigger |
| lat_i | input | LW (8) | Trigger latency in clocks |
| line_o | output | 1 | Serial line: header, address, error bit, sync pulse |
| smp_o | output | SW (8) | Channel value during the sample phase, zero otherwise |
| smp_vld_o | output | 1 | High while smp_o carries a channel value |

## Verification
A trigger driven before edge E is pushed at E and loaded at E+1, so a frame's clock 0 is the cycle after E+1. Channel k follows 12+k clocks later. The next queued frame follows immediately, and a sync pulse comes 70 clocks after the last sample. The bench drives on falling edges and walks the frame one falling edge per clock, checking each field at the exact clock the format assigns it. It never waits on an output to change. Sample values are a bench-side function of the write index, so the expected value for a column follows from the trigger's write index minus the latency.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  // Latency actually applied: anything past the buffer depth maps to the oldest column.
  function automatic int unsigned lat_clamp(input int unsigned lat, input int unsigned ncol);
    return (lat >= ncol) ? ncol - 1 : lat;
  endfunction

  // Column written 'lat' clocks before the column at 'wp', on a ring of 'ncol' columns.
  function automatic int unsigned col_back(input int unsigned wp, input int unsigned lat,
                                           input int unsigned ncol);
    return (wp + ncol - lat_clamp(lat, ncol)) % ncol;
  endfunction

endpackage

// File: rtl/tsp_colmem.sv
module tsp_colmem #(
  parameter int N_COL = 192,
  parameter int WW    = 1024,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic [WW-1:0] wr_data_i,
  input  logic          wr_hold_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [WW-1:0] rd_data_o
);

  logic [WW-1:0] mem [N_COL];

  always_ff @(posedge clk_i) begin
    if (!wr_hold_i) mem[wr_ptr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

  // R6: a held column keeps its contents across the edge
  a_r6_hold_keeps_column: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_hold_i |=> mem[$past(wr_ptr_i)] == $past(mem[wr_ptr_i]));

endmodule

// File: rtl/tsp_trigq.sv
module tsp_trigq #(
  parameter int QD = 4,
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_col_i,
  input  logic          pop_i,
  input  logic [AW-1:0] probe_col_i,
  output logic          empty_o,
  output logic [AW-1:0] head_o,
  output logic          hit_o,
  output logic          ovf_o
);

  localparam int PW = $clog2(QD);
  localparam int CW = $clog2(QD + 1);

  logic [AW-1:0] slot_q [QD];
  logic [PW-1:0] rp_q, wp_q;
  logic [CW-1:0] cnt_q;
  logic          full, accept;

  assign full    = (cnt_q == CW'(QD));
  assign accept  = push_i && (!full || pop_i);
  assign ovf_o   = push_i && full && !pop_i;
  assign empty_o = (cnt_q == '0);
  assign head_o  = slot_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) begin
        slot_q[wp_q] <= push_col_i;
        wp_q         <= wp_q + PW'(1);
      end
      if (pop_i) rp_q <= rp_q + PW'(1);
      case ({accept, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  // A waiting entry matches the probed column; the head leaving this edge is already read.
  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < QD; i++) begin
      if ((CW'(i) < cnt_q) && !(i == 0 && pop_i) && (slot_q[rp_q + PW'(i)] == probe_col_i))
        hit_o = 1'b1;
    end
  end

  a_r5_pop_needs_entry: assert property (@(posedge clk_i) disable iff (rst_i)
    pop_i |-> !empty_o);
  a_r5_depth_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= CW'(QD));

endmodule

// File: rtl/tsp_framer.sv
module tsp_framer #(
  parameter int N_CH = 128,
  parameter int SW   = 8,
  parameter int AW   = 8,
  parameter int HDR  = 3,
  parameter int PER  = 70
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               q_empty_i,
  input  logic [AW-1:0]      head_col_i,
  input  logic [N_CH*SW-1:0] word_i,
  input  logic               err_i,
  output logic               pop_o,
  output logic               line_o,
  output logic [SW-1:0]      smp_o,
  output logic               smp_vld_o
);

  localparam int ADR0 = HDR;
  localparam int ERRI = HDR + AW;
  localparam int SMP0 = ERRI + 1;
  localparam int LAST = SMP0 + N_CH - 1;
  localparam int IW   = $clog2(LAST + 1);
  localparam int PCW  = $clog2(PER);
  localparam int AB   = (AW > 1) ? $clog2(AW) : 1;

  logic               busy_q;
  logic [IW-1:0]      idx_q;
  logic [N_CH*SW-1:0] sh_q;
  logic [AW-1:0]      col_q;
  logic               eb_q;
  logic [PCW-1:0]     sc_q;
  logic               at_end, frame_start;
  logic [IW-1:0]      bpos;

  assign at_end      = busy_q && (idx_q == IW'(LAST));
  assign frame_start = !q_empty_i && (!busy_q || at_end);
  assign pop_o       = frame_start;
  assign bpos        = IW'(ERRI - 1) - idx_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      col_q  <= '0;
      eb_q   <= 1'b0;
      sc_q   <= '0;
      sh_q   <= '0;
    end else if (frame_start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      sh_q   <= word_i;
      col_q  <= head_col_i;
      eb_q   <= err_i;
      sc_q   <= '0;
    end else if (busy_q) begin
      if (at_end) begin
        busy_q <= 1'b0;
        sc_q   <= '0;
      end else begin
        idx_q <= idx_q + IW'(1);
        if (idx_q >= IW'(SMP0)) sh_q <= sh_q >> SW;
      end
    end else begin
      sc_q <= (sc_q == PCW'(PER - 1)) ? '0 : sc_q + PCW'(1);
    end
  end

  always_comb begin
    line_o = 1'b0;
    if (busy_q) begin
      if (idx_q < IW'(ADR0))       line_o = 1'b1;
      else if (idx_q < IW'(ERRI))  line_o = col_q[bpos[AB-1:0]];
      else if (idx_q == IW'(ERRI)) line_o = eb_q;
    end else begin
      line_o = (sc_q == PCW'(PER - 1)) && q_empty_i;
    end
  end

  assign smp_vld_o = busy_q && (idx_q >= IW'(SMP0));
  assign smp_o     = smp_vld_o ? sh_q[SW-1:0] : '0;

  // R8: an idle sync pulse lasts exactly one clock
  a_r8_sync_single: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_q && line_o) |=> !line_o);
  // R4: a waiting trigger starts its frame on the next edge when idle
  a_r4_start_next: assert property (@(posedge clk_i) disable iff (rst_i)
    (!busy_q && !q_empty_i) |=> (busy_q && idx_q == '0 && line_o));
  // R3 / R9: the last sample with nothing waiting returns to a quiet idle line
  a_r3_frame_end: assert property (@(posedge clk_i) disable iff (rst_i)
    (at_end && q_empty_i) |=> (!busy_q && !line_o && !smp_vld_o));

endmodule

// File: rtl/trig_sample_pipe.sv
module trig_sample_pipe #(
  parameter int N_CH  = 128,
  parameter int SW    = 8,
  parameter int N_COL = 192,
  parameter int QD    = 4,
  parameter int PER   = 70,
  parameter int HDR   = 3,
  parameter int LW    = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [N_CH*SW-1:0] samp_i,
  input  logic               trig_i,
  input  logic [LW-1:0]      lat_i,
  output logic               line_o,
  output logic [SW-1:0]      smp_o,
  output logic               smp_vld_o
);

  localparam int AW = $clog2(N_COL);
  localparam int WW = N_CH * SW;

  logic [AW-1:0] wp_q, rd_col, head_col;
  logic [WW-1:0] head_word;
  logic          err_q;
  logic          q_empty, q_pop, q_ovf, wr_blocked;

  assign rd_col = AW'(tsp_pkg::col_back(32'(wp_q), 32'(lat_i), N_COL));

  always_ff @(posedge clk_i) begin
    if (rst_i)                         wp_q <= '0;
    else if (wp_q == AW'(N_COL - 1))   wp_q <= '0;
    else                               wp_q <= wp_q + AW'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                     err_q <= 1'b0;
    else if (q_ovf || wr_blocked)  err_q <= 1'b1;
  end

  tsp_colmem #(.N_COL(N_COL), .WW(WW), .AW(AW)) u_mem (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_ptr_i  (wp_q),
    .wr_data_i (samp_i),
    .wr_hold_i (wr_blocked),
    .rd_addr_i (head_col),
    .rd_data_o (head_word)
  );

  tsp_trigq #(.QD(QD), .AW(AW)) u_q (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .push_i      (trig_i),
    .push_col_i  (rd_col),
    .pop_i       (q_pop),
    .probe_col_i (wp_q),
    .empty_o     (q_empty),
    .head_o      (head_col),
    .hit_o       (wr_blocked),
    .ovf_o       (q_ovf)
  );

  tsp_framer #(.N_CH(N_CH), .SW(SW), .AW(AW), .HDR(HDR), .PER(PER)) u_fr (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .q_empty_i  (q_empty),
    .head_col_i (head_col),
    .word_i     (head_word),
    .err_i      (err_q),
    .pop_o      (q_pop),
    .line_o     (line_o),
    .smp_o      (smp_o),
    .smp_vld_o  (smp_vld_o)
  );

  a_r1_ptr_wraps: assert property (@(posedge clk_i) disable iff (rst_i)
    (wp_q == AW'(N_COL - 1)) |=> (wp_q == '0));
  a_r2_col_in_ring: assert property (@(posedge clk_i) disable iff (rst_i)
    {1'b0, rd_col} < (AW+1)'(N_COL));
  a_r7_err_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    err_q |=> err_q);
  a_r7_err_on_event: assert property (@(posedge clk_i) disable iff (rst_i)
    (q_ovf || wr_blocked) |=> err_q);

endmodule

// File: tb/trig_sample_pipe_bench.sv
module trig_sample_pipe_bench;

  localparam int N_CH = 128;
  localparam int SW   = 8;
  localparam int NCOL = 192;
  localparam int FLEN = 140;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [N_CH*SW-1:0] din;
  logic               trig = 1'b0;
  logic [7:0]         lat = '0;
  logic               line_o, smp_vld_o;
  logic [SW-1:0]      smp_o;

  int checks = 0;
  int failures = 0;
  int nw = 0;

  always #4 clk = ~clk;

  trig_sample_pipe u_trig_sample_pipe (
    .clk_i(clk), .rst_i(rst), .samp_i(din), .trig_i(trig), .lat_i(lat),
    .line_o(line_o), .smp_o(smp_o), .smp_vld_o(smp_vld_o)
  );

  function automatic int fval(input int n, input int ch);
    return (n * 7 + ch * 3) & 8'hFF;
  endfunction

  function automatic int mcol(input int x);
    return ((x % NCOL) + NCOL) % NCOL;
  endfunction

  always @(posedge clk) begin
    if (rst) nw <= 0;
    else     nw <= nw + 1;
  end

  always @(negedge clk) begin
    for (int ch = 0; ch < N_CH; ch++) din[ch*SW +: SW] = SW'(fval(nw, ch));
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trig = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Single trigger; returns at the negedge of frame clock 0. R4 timing checked here.
  task automatic fire(input int l, output int n0);
    @(negedge clk);
    lat = 8'(l);
    trig = 1'b1;
    n0 = nw;
    @(negedge clk);
    trig = 1'b0;
    chk(line_o == 1'b0, "R4", "line between push and start", int'(line_o), 0);
    @(negedge clk);
    chk(line_o == 1'b1 && !smp_vld_o, "R4", "frame clock 0 header", int'(line_o), 1);
  endtask

  // Called at the negedge of frame clock 0; ends at the negedge of the last sample.
  task automatic read_frame(input int ecol, input int eerr, input int nsrc, input string req);
    int hdr_bad = 0, adr = 0, eb = 0, smp_bad = 0, fa = 0, fe = 0, frm_bad = 0;
    for (int i = 0; i < FLEN; i++) begin
      if (i > 0) @(negedge clk);
      if (i < 3) begin
        if (line_o !== 1'b1) hdr_bad++;
      end else if (i < 11) begin
        adr = (adr << 1) | int'(line_o);
      end else if (i == 11) begin
        eb = int'(line_o);
      end else begin
        if (line_o !== 1'b0) frm_bad++;
        if (int'(smp_o) != fval(nsrc, i - 12)) begin
          if (smp_bad == 0) begin fa = int'(smp_o); fe = fval(nsrc, i - 12); end
          smp_bad++;
        end
      end
      if (smp_vld_o !== (i >= 12)) frm_bad++;
    end
    chk(hdr_bad == 0, "R3", "header ones", hdr_bad, 0);
    chk(adr == ecol, req, "column address", adr, ecol);
    chk(eb == eerr, "R7", "error bit", eb, eerr);
    chk(smp_bad == 0, req, "first wrong sample", fa, fe);
    chk(frm_bad == 0, "R3", "sample phase framing", frm_bad, 0);
  endtask

  // Sample i=1 is the current cycle; pulse expected on every 70th.
  task automatic sync_window(input int n, input string req);
    int bad = 0, first = -1;
    for (int i = 1; i <= n; i++) begin
      if (i > 1) @(negedge clk);
      if (line_o !== (i % 70 == 0)) begin
        if (first < 0) first = i;
        bad++;
      end
    end
    chk(bad == 0, req, "sync pattern first bad cycle", first, -1);
  endtask

  task automatic t_reset_sync();
    do_reset();
    chk(line_o == 1'b0 && smp_vld_o == 1'b0, "R10", "outputs after reset",
        int'(line_o) + int'(smp_vld_o), 0);
    sync_window(141, "R8");
  endtask

  task automatic t_latency();
    int n0;
    repeat (200) @(negedge clk);
    fire(37, n0);
    read_frame(mcol(n0 - 37), 0, n0 - 37, "R1");
    fire(0, n0);
    read_frame(mcol(n0), 0, n0, "R1");
  endtask

  task automatic t_clamp_and_gap();
    int n0;
    fire(250, n0);
    read_frame(mcol(n0 - 191), 0, n0 - 191, "R2");
    @(negedge clk);
    sync_window(70, "R9");
  endtask

  task automatic t_midframe_reset();
    int n0;
    fire(10, n0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(line_o == 1'b0 && smp_vld_o == 1'b0, "R10", "frame cut by reset",
        int'(line_o) + int'(smp_vld_o), 0);
    @(negedge clk);
    rst = 1'b0;
    sync_window(140, "R10");
  endtask

  task automatic t_protect();
    int n0, n1;
    do_reset();
    repeat (200) @(negedge clk);
    @(negedge clk);
    lat = 8'd150;
    trig = 1'b1;
    n0 = nw;
    @(negedge clk);
    n1 = nw;
    @(negedge clk);
    trig = 1'b0;
    read_frame(mcol(n0 - 150), 0, n0 - 150, "R5");
    @(negedge clk);
    read_frame(mcol(n1 - 150), 1, n1 - 150, "R6");
  endtask

  task automatic t_overflow();
    int nn[6];
    int n0;
    do_reset();
    repeat (200) @(negedge clk);
    @(negedge clk);
    lat = 8'd20;
    trig = 1'b1;
    nn[0] = nw;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      nn[k] = nw;
    end
    @(negedge clk);
    trig = 1'b0;
    repeat (135) @(negedge clk);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      read_frame(mcol(nn[k] - 20), 1, nn[k] - 20, "R5");
    end
    @(negedge clk);
    sync_window(70, "R5");
    fire(5, n0);
    read_frame(mcol(n0 - 5), 1, n0 - 5, "R7");
    do_reset();
    repeat (10) @(negedge clk);
    fire(5, n0);
    read_frame(mcol(n0 - 5), 0, n0 - 5, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_sync();
    t_latency();
    t_clamp_and_gap();
    t_midframe_reset();
    t_protect();
    t_overflow();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule